// File: doc/BRIEF.md
# DMA Channel Set/Clear Control Register File

This block is the memory-mapped register file of a DMA controller with up to 32 channels. Each per-channel attribute (burst-only, request mask, channel enable, alternate-structure select and high priority) is kept as one bit vector. That vector has two bus addresses. Writing ones at the set address turns bits on, and writing ones at the clear address turns them off. Bits written as zero are left as they are. Software can therefore change one channel without a read-modify-write, and cannot race the hardware.

The block also holds four other pieces of state. A write-only configuration register gives the master enable and three bus-protection bits. A sticky per-channel completion register is set by the sequencer and cleared by software writing ones. A completion mask decides where each channel's completion goes: to its peripheral, or into a single combined completion line. A bus-error flag is also kept here. Arbitration and data movement live elsewhere. The bus is a single-cycle read/write port: writes take effect on the clock edge, and read data follows the address combinationally.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, every attribute vector, the completion vector, the completion mask, the error flag, the master enable and the protection bits are 0.
- R2: A write of 1s to an attribute's set address (burst-only 0x18, request mask 0x20, enable 0x28, alternate 0x30, priority 0x38) sets those bits, and 0 bits are unchanged. A read of the set address returns the vector, and the matching output port shows it.
- R3: A write of 1s to an attribute's clear address (set address + 4) clears those bits, and 0 bits are unchanged. A read of a clear address returns 0.
- R4: Bit c of the completion vector (read at 0x504) becomes 1 one cycle after the done-event input c is high. It stays 1 until software writes 1 to bit c at 0x504. If the event and the clearing write fall in the same cycle, the bit ends up 1.
- R5: The completion mask is read/write at 0x520. Where a mask bit is 1, the channel's per-peripheral done and active outputs are forced low. Where it is 0, they follow the completion bit and the active input.
- R6: The combined done output is the OR over channels of the completion bit AND the mask bit.
- R7: Writing 0x04 loads master enable from bit 0 and the protection outputs from bits 7:5. A read of 0x04 returns 0. The status word at 0x00 reads (NUM_CH-1) in bits 20:16 and master enable in bit 0, and every other bit is 0. This gives 0x001F0000 after reset for 32 channels.
- R8: The error flag (bit 0 at 0x4C) is set by the error input and cleared by writing 1 to bit 0. A write of 0 has no effect, and a set in the same cycle as the clear wins.
- R9: Write data bits at or above NUM_CH are ignored by every per-channel register, and those bits read as 0.
- R10: Reads of unmapped offsets return 0, and writes to them change no state.
- R11: The wait-on-request word at 0x10 is read-only. It returns the parameter WAIT_INIT (default 0xFFFF1EFF) masked to the implemented channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hw_done | input | NUM_CH | Per-channel completion events from the sequencer |
| hw_active | input | NUM_CH | Per-channel active state from the sequencer |
| hw_err | input | 1 | Bus error event |
| burst_only | output | NUM_CH | Burst-only attribute |
| req_mask | output | NUM_CH | Request mask attribute |
| ch_enable | output | NUM_CH | Channel enable attribute |
| alt_sel | output | NUM_CH | Alternate structure select |
| hi_prio | output | NUM_CH | High priority attribute |
| master_en | output | 1 | Controller master enable |
| prot | output | 3 | Protection bits |
| err_flag | output | 1 | Bus error flag |
| periph_done | output | NUM_CH | Completion routed to peripherals |
| periph_active | output | NUM_CH | Active state routed to peripherals |
| done_all | output | 1 | Combined completion |

## Verification
Every stored bit drives an output port directly. A wrong bit in an attribute vector, the configuration or the error flag therefore shows on its port, and in the read word, one cycle after the write or event that caused it. A set/clear decode fault changes the wrong vector, and the per-attribute read-back exposes this at once. A wrong completion or mask bit shows in the same cycle on periph_done, periph_active and done_all, and the masked and unmasked cases show opposite polarities.

// File: rtl/chan_ctl_pkg.sv
// Shared address map and helpers for the channel control register file.
// Assumes a 12-bit byte offset bus and 32-bit data.
package chan_ctl_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_ATTR = 5;
    // Attribute order follows the set-address spacing of 8 bytes.
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CONFIG  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_WAIT    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ATTR0   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_ERROR   = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_DONE    = 12'h504;
    localparam logic [ADDR_W-1:0] OFS_DMASK   = 12'h520;

    // Set address of attribute idx; its clear address is this plus 4.
    function automatic logic [ADDR_W-1:0] attr_set_ofs(input int idx);
        return OFS_ATTR0 + ADDR_W'(8 * idx);
    endfunction
endpackage

// File: rtl/setclr_bank.sv
// One per-channel attribute vector written through a set address and a
// clear address. Assumes single-cycle writes; 0 bits in the data are no-ops.
module setclr_bank
    import chan_ctl_pkg::*;
#(
    parameter int                W       = 32,
    parameter logic [ADDR_W-1:0] SET_OFS = 12'h018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      q
);
    localparam logic [ADDR_W-1:0] CLR_OFS = SET_OFS + ADDR_W'(4);

    logic set_hit, clr_hit;
    assign set_hit = wr && (addr == SET_OFS);
    assign clr_hit = wr && (addr == CLR_OFS);

    // Update the vector from set or clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (set_hit) q <= q | wdata;
        else if (clr_hit) q <= q & ~wdata;
    end

    a_r2_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((q & $past(wdata)) == $past(wdata)));
    a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((q & $past(q)) == $past(q)));
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((q & $past(wdata)) == '0));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_hit || clr_hit) |=> $stable(q));
endmodule

// File: rtl/w1c_sticky.sv
// Sticky flags set by hardware events and cleared by writing 1s.
// Assumes an event and a clearing write on the same bit resolve to set.
module w1c_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_bits;
    assign clr_bits = clr_wr ? clr_data : '0;

    // Clear requested bits, then let events override.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_bits) | hw_set;
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(hw_set)) == $past(hw_set)));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/done_route.sv
// Routes completion and active state by the completion mask: masked
// channels are hidden from peripherals and feed the combined line.
module done_route #(
    parameter int W = 32
) (
    input  logic [W-1:0] done_q,
    input  logic [W-1:0] active,
    input  logic [W-1:0] mask,
    output logic [W-1:0] periph_done,
    output logic [W-1:0] periph_active,
    output logic         done_all
);
    // Gate per-peripheral outputs and reduce the masked completions.
    always_comb begin
        periph_done   = done_q & ~mask;
        periph_active = active & ~mask;
        done_all      = |(done_q & mask);
    end

    // R5 and R6: a channel is never both routed out and counted in combined.
    always_comb begin
        a_r5_masked_quiet: assert (((periph_done | periph_active) & mask) == '0);
        a_r6_combined: assert (!done_all || ((done_q & ~periph_done) != '0));
    end
endmodule

// File: rtl/chan_ctl_regs.sv
// Register file of a DMA controller: set/clear attribute vectors,
// configuration, sticky completion with mask routing and error flag.
// Assumes combinational read data and single-cycle writes.
module chan_ctl_regs
    import chan_ctl_pkg::*;
#(
    parameter int          NUM_CH    = 32,
    parameter logic [31:0] WAIT_INIT = 32'hFFFF_1EFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] hw_done,
    input  logic [NUM_CH-1:0] hw_active,
    input  logic              hw_err,
    output logic [NUM_CH-1:0] burst_only,
    output logic [NUM_CH-1:0] req_mask,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] alt_sel,
    output logic [NUM_CH-1:0] hi_prio,
    output logic              master_en,
    output logic [2:0]        prot,
    output logic              err_flag,
    output logic [NUM_CH-1:0] periph_done,
    output logic [NUM_CH-1:0] periph_active,
    output logic              done_all
);
    localparam logic [31:0] CH_MASK = 32'((64'd1 << NUM_CH) - 64'd1);
    localparam logic [4:0]  CH_TOP  = 5'(NUM_CH - 1);

    logic [NUM_ATTR-1:0][NUM_CH-1:0] attr_q;
    logic [NUM_CH-1:0] done_q, dmask_q;
    logic [NUM_CH-1:0] wdata_ch;
    logic [0:0]        err_q;

    assign wdata_ch = bus_wdata[NUM_CH-1:0];

    // One set/clear bank per attribute, addresses 8 bytes apart.
    for (genvar i = 0; i < NUM_ATTR; i++) begin : g_attr
        setclr_bank #(.W(NUM_CH), .SET_OFS(attr_set_ofs(i))) u_bank (
            .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
            .wdata(wdata_ch), .q(attr_q[i])
        );
    end

    assign burst_only = attr_q[0];
    assign req_mask   = attr_q[1];
    assign ch_enable  = attr_q[2];
    assign alt_sel    = attr_q[3];
    assign hi_prio    = attr_q[4];

    w1c_sticky #(.W(NUM_CH)) u_done (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_done),
        .clr_wr(bus_wr && bus_addr == OFS_DONE), .clr_data(wdata_ch), .q(done_q)
    );

    w1c_sticky #(.W(1)) u_err (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_err),
        .clr_wr(bus_wr && bus_addr == OFS_ERROR), .clr_data(bus_wdata[0]), .q(err_q)
    );
    assign err_flag = err_q[0];

    // Configuration and completion mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            prot      <= 3'b000;
            dmask_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CONFIG) begin
                master_en <= bus_wdata[0];
                prot      <= bus_wdata[7:5];
            end
            if (bus_addr == OFS_DMASK) dmask_q <= wdata_ch;
        end
    end

    done_route #(.W(NUM_CH)) u_route (
        .done_q(done_q), .active(hw_active), .mask(dmask_q),
        .periph_done(periph_done), .periph_active(periph_active), .done_all(done_all)
    );

    // Read multiplexer; unmapped and write-only offsets return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_ATTR; i++)
            if (bus_addr == attr_set_ofs(i)) bus_rdata = 32'(attr_q[i]);
        unique case (bus_addr)
            OFS_STATUS: bus_rdata = {11'd0, CH_TOP, 15'd0, master_en};
            OFS_WAIT:   bus_rdata = WAIT_INIT & CH_MASK;
            OFS_ERROR:  bus_rdata = {31'd0, err_flag};
            OFS_DONE:   bus_rdata = 32'(done_q);
            OFS_DMASK:  bus_rdata = 32'(dmask_q);
            default: ;
        endcase
    end

    a_r7_config: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CONFIG) |=> (master_en == $past(bus_wdata[0])
                                                && prot == $past(bus_wdata[7:5])));
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_DONE || bus_addr == OFS_DMASK) |-> ((bus_rdata & ~CH_MASK) == '0));
endmodule

// File: tb/chan_ctl_regs_tb_top.sv
// Directed bench: one task per scenario, 24 channels to reach unimplemented bits.
module chan_ctl_regs_tb_top;
    localparam int NCH = 24;
    logic clk = 0, rst_n = 0, bus_wr = 0, hw_err = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NCH-1:0] hw_done = '0, hw_active = '0;
    logic [NCH-1:0] burst_only, req_mask, ch_enable, alt_sel, hi_prio, periph_done, periph_active;
    logic master_en, err_flag, done_all;
    logic [2:0] prot;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    chan_ctl_regs #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_done(hw_done),
        .hw_active(hw_active), .hw_err(hw_err), .burst_only(burst_only),
        .req_mask(req_mask), .ch_enable(ch_enable), .alt_sel(alt_sel),
        .hi_prio(hi_prio), .master_en(master_en), .prot(prot), .err_flag(err_flag),
        .periph_done(periph_done), .periph_active(periph_active), .done_all(done_all)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] attr_port(input int i);
        case (i)
            0: return 32'(burst_only);
            1: return 32'(req_mask);
            2: return 32'(ch_enable);
            3: return 32'(alt_sel);
            default: return 32'(hi_prio);
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) begin
            rd(12'h018 + 12'(8*i), d); check("R1 attr reset", d, 0);
        end
        rd(12'h504, d); check("R1 done reset", d, 0);
        rd(12'h520, d); check("R1 mask reset", d, 0);
        rd(12'h04C, d); check("R1 error reset", d, 0);
        rd(12'h000, d); check("R7 status reset", d, 32'h0017_0000);
        rd(12'h010, d); check("R11 wait readback", d, 32'h00FF_1EFF);
        check("R1 cfg outputs", {28'd0, prot, master_en}, 0);
    endtask

    task automatic t_setclr();
        logic [31:0] d, exp;
        for (int i = 0; i < 5; i++) begin
            logic [11:0] so = 12'h018 + 12'(8*i);
            wr(so, 32'hFFA5_5A3C); exp = 32'h00A5_5A3C;
            rd(so, d); check("R2 R9 set readback", d, exp);
            wr(so, 32'h0000_00C0); exp |= 32'hC0;
            rd(so, d); check("R2 set keeps others", d, exp);
            check("R2 port", attr_port(i), exp);
            wr(so + 12'd4, 32'hFF00_003C); exp &= ~32'h3C;
            rd(so, d); check("R3 clear", d, exp);
            rd(so + 12'd4, d); check("R3 clear reads zero", d, 0);
            wr(so, 0); wr(so + 12'd4, 0);
            rd(so, d); check("R2 R3 zero writes no effect", d, exp);
            wr(so + 12'd4, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_done();
        logic [31:0] d;
        @(negedge clk); hw_done = 24'h8; @(negedge clk); hw_done = '0;
        rd(12'h504, d); check("R4 done set", d, 32'h8);
        repeat (3) @(negedge clk);
        rd(12'h504, d); check("R4 sticky", d, 32'h8);
        wr(12'h504, 32'h10); rd(12'h504, d); check("R4 other bit clear", d, 32'h8);
        wr(12'h504, 32'h8);  rd(12'h504, d); check("R4 w1c", d, 0);
        @(negedge clk); bus_addr = 12'h504; bus_wdata = 32'h20; bus_wr = 1; hw_done = 24'h20;
        @(negedge clk); bus_wr = 0; hw_done = '0;
        rd(12'h504, d); check("R4 set wins", d, 32'h20);
        wr(12'h504, 32'h20);
    endtask

    task automatic t_mask();
        @(negedge clk); hw_done = 24'h8; @(negedge clk); hw_done = '0; hw_active = 24'h8;
        #1;
        check("R5 unmasked done", 32'(periph_done), 32'h8);
        check("R5 unmasked active", 32'(periph_active), 32'h8);
        check("R6 excluded", {31'd0, done_all}, 0);
        wr(12'h520, 32'hFF00_0008);
        #1;
        check("R5 masked done", 32'(periph_done), 0);
        check("R5 masked active", 32'(periph_active), 0);
        check("R6 included", {31'd0, done_all}, 1);
        wr(12'h504, 32'h8); #1;
        check("R6 cleared", {31'd0, done_all}, 0);
        wr(12'h520, 0); hw_active = '0;
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        wr(12'h004, 32'h0000_00E1);
        check("R7 cfg ports", {28'd0, prot, master_en}, 32'hF);
        rd(12'h004, d); check("R7 write-only", d, 0);
        rd(12'h000, d); check("R7 status enable", d, 32'h0017_0001);
        wr(12'h004, 32'h0000_0040);
        check("R7 cfg reload", {28'd0, prot, master_en}, 32'h4);
    endtask

    task automatic t_err();
        logic [31:0] d;
        @(negedge clk); hw_err = 1; @(negedge clk); hw_err = 0;
        rd(12'h04C, d); check("R8 err set", d, 1);
        wr(12'h04C, 0); rd(12'h04C, d); check("R8 zero no effect", d, 1);
        wr(12'h04C, 1); rd(12'h04C, d); check("R8 clear", d, 0);
        @(negedge clk); bus_addr = 12'h04C; bus_wdata = 1; bus_wr = 1; hw_err = 1;
        @(negedge clk); bus_wr = 0; hw_err = 0;
        check("R8 set wins", {31'd0, err_flag}, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(12'h028, 32'h0000_1234);
        wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, d); check("R10 unmapped read", d, 0);
        wr(12'h500, 32'hFFFF_FFFF); rd(12'h028, d); check("R10 no state change", d, 32'h1234);
        wr(12'h010, 32'h0); rd(12'h010, d); check("R11 read-only", d, 32'h00FF_1EFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_setclr(); t_done(); t_mask(); t_cfg(); t_err(); t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule